// File: doc/BRIEF.md
# Programmable 3x3 Color Space Converter

This block converts a stream of three-component pixels from one color space to another. Each output component is a weighted sum of the three input components, plus a per-row constant, rounded and then saturated to eight bits. The twelve-word coefficient bank and a one-bit enable are loaded through a simple write port. When the enable is clear, pixels pass through unchanged with the same latency. A parameter selects between two coefficient encodings. The legacy encoding uses 10 fractional bits and a full-word row constant. The extended encoding uses 17 fractional bits and packs a signed input offset and an integer output constant into the fourth word of each row.

Writes land in a staged copy of the bank. The copy in use changes only when a frame-start strobe arrives. On that strobe the input is held off until every pixel already in the pipeline has left, and then the staged copy is installed, so no pixel is ever computed with a mix of old and new settings. Pixels travel on a valid/ready stream through a three-stage pipeline. A stall at the output freezes every stage.

Top module: `pix_csc`

## Requirements
- R1: After reset, out_valid is 0, out_pix is 0, and in_ready is 1 while frame_start is low. The installed enable is 0 and every installed coefficient word is 0.
- R2: While the installed enable is 0, each output pixel equals its input pixel bit for bit, with the same latency as a converted pixel.
- R3: With EXT_FMT=0, input component j is in_pix[8j+7:8j], read as unsigned. Word 4i+j (j<3) is coefficient c_ij and word 4i+3 is constant K_i, both 32-bit two's complement. Output component i, at out_pix[8i+7:8i], is floor((sum_j c_ij*x_j + K_i + 2^9) / 2^10), clamped as in R5.
- R4: With EXT_FMT=1, coefficients carry 17 fractional bits. Bits [31:16] of word 4j+3 are a signed offset d_j added to input j before the multiply. Bits [15:0] of word 4i+3 are a signed integer constant for output i, scaled by 2^17 and added after the sum. The result is then rounded with 2^16 and shifted down by 17.
- R5: A rounded result below 0 gives 0, a result above 255 gives 255, and values in between pass through unchanged.
- R6: A pixel accepted in cycle t (in_valid and in_ready high at the edge) appears with out_valid in cycle t+3, provided out_ready is high in cycles t+1 and t+2. One pixel can be accepted every cycle.
- R7: While out_valid is 1 and out_ready is 0, out_valid and out_pix hold and in_ready is 0.
- R8: Write addresses 0 to 11 select coefficient words in row-major order, four words per row. Address 12 is the control word, whose bit 0 is the enable. Writes to addresses 13 to 15 change nothing.
- R9: A write has no effect on output pixels until the next frame-start install.
- R10: In a cycle with frame_start high, and afterwards until the pipeline is empty, in_ready is 0. The staged bank and enable are installed at the first edge at which the pipeline is empty, which can be the frame_start edge itself. Pixels accepted afterwards use the new values.
- R11: A write in the same cycle as an install is not part of that install. It takes effect at the next frame start.
- R12: Swapping coefficient columns 1 and 2 in every row, and feeding the pixel with components 1 and 2 swapped, gives the same output as the unswapped bank on the original pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register write address |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle strobe that installs the staged settings |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | 24 | Input components, component j in bits [8j+7:8j] |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_pix | output | 24 | Output components, component i in bits [8i+7:8i] |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a register write and the install that a frame-start strobe triggers. The second pair is a frame-start strobe and pixels still in flight, possibly behind an output stall. The bench raises cfg_we and frame_start together with the pipeline empty, and judges from later output pixels that the write was held back for the next frame. It also pulses frame_start in the middle of a back-to-back burst, while out_ready is toggled, and compares in_ready and every output pixel, every clock, against a reference that installs only once the in-flight pixel count reaches zero.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = WORD_W / 2;
  localparam int PIX_W    = 8;
  localparam int N_CH     = 3;
  localparam int ROW_W    = N_CH + 1;
  localparam int N_WORDS  = N_CH * ROW_W;
  localparam int CTRL_ADDR = N_WORDS;
  localparam int OPD_W    = HALF_W + 2;
  localparam int ACC_W    = 64;
  localparam int unsigned FRAC_LEG = 10;
  localparam int unsigned FRAC_EXT = 17;
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

  typedef logic [WORD_W-1:0] word_t;

  // input component plus optional signed offset from the upper half of a row word
  function automatic logic signed [OPD_W-1:0] offset_input(logic [PIX_W-1:0] x, word_t w, bit ext);
    logic signed [OPD_W-1:0] r;
    r = $signed({{(OPD_W-PIX_W){1'b0}}, x});
    if (ext) r = r + OPD_W'($signed(w[WORD_W-1:HALF_W]));
    return r;
  endfunction

  function automatic logic signed [ACC_W-1:0] mul_term(word_t c, logic signed [OPD_W-1:0] opd);
    return ACC_W'($signed(c)) * ACC_W'(opd);
  endfunction

  // constant added after the matrix sum, aligned to the fractional scale
  function automatic logic signed [ACC_W-1:0] post_const(word_t w, bit ext, int unsigned frac);
    logic signed [ACC_W-1:0] k;
    if (ext) k = ACC_W'($signed(w[HALF_W-1:0])) <<< frac;
    else     k = ACC_W'($signed(w));
    return k;
  endfunction

  // half-LSB rounding at the fractional boundary, then clamp to the pixel range
  function automatic logic [PIX_W-1:0] round_sat(logic signed [ACC_W-1:0] acc, int unsigned frac);
    logic signed [ACC_W-1:0] half;
    logic signed [ACC_W-1:0] q;
    half = ACC_W'(1) << (frac - 1);
    q = (acc + half) >>> frac;
    if (q[ACC_W-1]) return '0;
    if (q > PIX_MAX) return '1;
    return q[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/csc_regbank.sv
module csc_regbank
  import csc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  input  logic              frame_start,
  input  logic              pipe_empty,
  output word_t             bank_act [N_WORDS],
  output logic              en_act,
  output logic              hold_in,
  output logic              commit
);
  word_t bank_shd [N_WORDS];
  logic  en_shd;
  logic  pend_q;

  // a strobe, or one still waiting for the pipeline to drain
  assign hold_in = pend_q | frame_start;
  assign commit  = hold_in & pipe_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_WORDS; k++) begin
        bank_shd[k] <= '0;
        bank_act[k] <= '0;
      end
      en_shd <= 1'b0;
      en_act <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= hold_in & ~pipe_empty;
      if (commit) begin
        for (int k = 0; k < N_WORDS; k++) bank_act[k] <= bank_shd[k];
        en_act <= en_shd;
      end
      if (wr_en) begin
        if (wr_addr == ADDR_W'(CTRL_ADDR)) en_shd <= wr_data[0];
        for (int k = 0; k < N_WORDS; k++)
          if (wr_addr == ADDR_W'(k)) bank_shd[k] <= wr_data;
      end
    end
  end

  a_r11_no_install_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !pipe_empty) |=> $stable(en_act));
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter bit EXT_FMT = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic                  load,
  input  logic [N_CH*PIX_W-1:0] in_pix,
  input  logic                  en,
  input  word_t                 bank [N_WORDS],
  output logic                  out_valid,
  output logic [N_CH*PIX_W-1:0] out_pix,
  output logic                  empty
);
  localparam int unsigned FRAC = EXT_FMT ? FRAC_EXT : FRAC_LEG;

  logic s1_v, s2_v, s3_v;
  logic [N_CH*PIX_W-1:0] s1_raw, s2_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s2_v   <= 1'b0;
      s3_v   <= 1'b0;
      s1_raw <= '0;
      s2_raw <= '0;
    end else if (adv) begin
      s1_v   <= load;
      s2_v   <= s1_v;
      s3_v   <= s2_v;
      s1_raw <= in_pix;
      s2_raw <= s1_raw;
    end
  end

  assign out_valid = s3_v;
  assign empty     = ~(s1_v | s2_v | s3_v);

  // stage 1: per-input offset
  for (genvar j = 0; j < N_CH; j++) begin : g_col
    logic signed [OPD_W-1:0] opd;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   opd <= '0;
      else if (adv) opd <= offset_input(in_pix[j*PIX_W +: PIX_W], bank[j*ROW_W + N_CH], EXT_FMT);
    end
  end

  // stage 2: products, stage 3: sum, constant, rounding, clamp
  for (genvar i = 0; i < N_CH; i++) begin : g_row
    logic signed [ACC_W-1:0] sum;
    logic [PIX_W-1:0]        res;
    for (genvar j = 0; j < N_CH; j++) begin : g_term
      logic signed [ACC_W-1:0] prod;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   prod <= '0;
        else if (adv) prod <= mul_term(bank[i*ROW_W + j], g_col[j].opd);
      end
    end
    assign sum = g_term[0].prod + g_term[1].prod + g_term[2].prod
               + post_const(bank[i*ROW_W + N_CH], EXT_FMT, FRAC);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   res <= '0;
      else if (adv) res <= en ? round_sat(sum, FRAC) : s2_raw[i*PIX_W +: PIX_W];
    end
    assign out_pix[i*PIX_W +: PIX_W] = res;
  end

  a_r7_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && s3_v) |=> (s3_v && $stable(out_pix)));
endmodule

// File: rtl/pix_csc.sv
module pix_csc
  import csc_pkg::*;
#(
  parameter bit EXT_FMT = 1'b0,
  parameter int ADDR_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [WORD_W-1:0]     cfg_wdata,
  input  logic                  frame_start,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [N_CH*PIX_W-1:0] in_pix,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [N_CH*PIX_W-1:0] out_pix
);
  word_t bank_act [N_WORDS];
  logic  en_act;
  logic  hold_in;
  logic  commit;
  logic  pipe_empty;
  logic  adv;
  logic  load;

  // a stall at the output freezes every stage
  assign adv      = out_ready | ~out_valid;
  assign in_ready = adv & ~hold_in;
  assign load     = in_valid & in_ready;

  csc_regbank #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_we),
    .wr_addr     (cfg_addr),
    .wr_data     (cfg_wdata),
    .frame_start (frame_start),
    .pipe_empty  (pipe_empty),
    .bank_act    (bank_act),
    .en_act      (en_act),
    .hold_in     (hold_in),
    .commit      (commit)
  );

  csc_datapath #(.EXT_FMT(EXT_FMT)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .load      (load),
    .in_pix    (in_pix),
    .en        (en_act),
    .bank      (bank_act),
    .out_valid (out_valid),
    .out_pix   (out_pix),
    .empty     (pipe_empty)
  );

  a_r6_three_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready ##1 out_ready |=> out_valid);

  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !en_act) ##1 out_ready ##1 out_ready |=> (out_pix == $past(in_pix, 3)));

  a_r7_output_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  a_r7_no_take_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r10_strobe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !in_ready);

  a_r10_enable_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_empty |=> $stable(en_act));

  for (genvar g = 0; g < N_WORDS; g++) begin : g_frz
    a_r10_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !pipe_empty |=> $stable(bank_act[g]));
  end
endmodule

// File: tb/test_pix_csc.sv
`timescale 1ns/1ps
module test_pix_csc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        in_valid = 1'b0;
  logic [23:0] in_pix = '0;
  logic        out_ready = 1'b1;
  logic        i_rdy0, i_rdy1, o_v0, o_v1;
  logic [23:0] o_p0, o_p1;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  pix_csc #(.EXT_FMT(1'b0)) i_pix_csc (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .in_valid(in_valid), .in_ready(i_rdy0), .in_pix(in_pix),
    .out_valid(o_v0), .out_ready(out_ready), .out_pix(o_p0));

  pix_csc #(.EXT_FMT(1'b1)) i_pix_csc_ext (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .in_valid(in_valid), .in_ready(i_rdy1), .in_pix(in_pix),
    .out_valid(o_v1), .out_ready(out_ready), .out_pix(o_p1));

  // reference state
  logic [31:0] shd [12];
  logic [31:0] act [12];
  logic        en_shd_m, en_m, pend_m;
  logic        mv [3];
  logic [23:0] md0 [3];
  logic [23:0] md1 [3];
  string       mt [3];

  logic [31:0] bank_leg [12];
  logic [31:0] bank_ext [12];
  logic [31:0] bank_swp [12];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] a, input logic [31:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, a, e);
    end
  endtask

  function automatic logic [23:0] ref_px(input bit ext, input logic [23:0] px);
    logic [23:0] r;
    longint acc, opd;
    int frac;
    if (!en_m) return px;
    frac = ext ? 17 : 10;
    for (int i = 0; i < 3; i++) begin
      acc = 0;
      for (int j = 0; j < 3; j++) begin
        opd = longint'(px[8*j +: 8]);
        if (ext) opd += longint'($signed(act[4*j+3][31:16]));
        acc += longint'($signed(act[4*i+j])) * opd;
      end
      if (ext) acc += longint'($signed(act[4*i+3][15:0])) * (longint'(1) << frac);
      else     acc += longint'($signed(act[4*i+3]));
      acc += longint'(1) << (frac - 1);
      acc = acc >>> frac;
      r[8*i +: 8] = (acc < 0) ? 8'd0 : (acc > 255) ? 8'd255 : acc[7:0];
    end
    return r;
  endfunction

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    bit exp_rdy, adv, empty, commit;
    if (!rst_n) begin
      for (int k = 0; k < 12; k++) begin shd[k] = '0; act[k] = '0; end
      en_shd_m = 1'b0; en_m = 1'b0; pend_m = 1'b0;
      for (int k = 0; k < 3; k++) begin mv[k] = 1'b0; md0[k] = '0; md1[k] = '0; mt[k] = "R1"; end
    end else begin
      chk(o_v0 == mv[2], "R6", "legacy out_valid", 32'(o_v0), 32'(mv[2]));
      chk(o_v1 == mv[2], "R6", "extended out_valid", 32'(o_v1), 32'(mv[2]));
      if (mv[2]) begin
        chk(o_p0 == md0[2], mt[2], "legacy out_pix", 32'(o_p0), 32'(md0[2]));
        chk(o_p1 == md1[2], mt[2], "extended out_pix", 32'(o_p1), 32'(md1[2]));
      end
      exp_rdy = !frame_start && !pend_m && (out_ready || !mv[2]);
      chk(i_rdy0 == exp_rdy, (frame_start || pend_m) ? "R10" : "R7", "legacy in_ready", 32'(i_rdy0), 32'(exp_rdy));
      chk(i_rdy1 == exp_rdy, (frame_start || pend_m) ? "R10" : "R7", "extended in_ready", 32'(i_rdy1), 32'(exp_rdy));
      adv = out_ready || !mv[2];
      empty = !mv[0] && !mv[1] && !mv[2];
      commit = (pend_m || frame_start) && empty;
      if (adv) begin
        mv[2] = mv[1]; md0[2] = md0[1]; md1[2] = md1[1]; mt[2] = mt[1];
        mv[1] = mv[0]; md0[1] = md0[0]; md1[1] = md1[0]; mt[1] = mt[0];
        mv[0] = in_valid && exp_rdy;
        md0[0] = ref_px(1'b0, in_pix);
        md1[0] = ref_px(1'b1, in_pix);
        mt[0] = tag;
      end
      if (commit) begin
        for (int k = 0; k < 12; k++) act[k] = shd[k];
        en_m = en_shd_m;
      end
      if (cfg_we) begin
        if (cfg_addr < 12) shd[cfg_addr] = cfg_wdata;
        else if (cfg_addr == 12) en_shd_m = cfg_wdata[0];
      end
      pend_m = (pend_m || frame_start) && !empty;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send_pix(input logic [23:0] p);
    bit ok;
    in_valid = 1'b1;
    in_pix = p;
    do begin
      @(negedge clk);
      ok = i_rdy0;
      @(posedge clk); #1;
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic load_bank(input logic [31:0] b [12]);
    for (int k = 0; k < 12; k++) cfg_write(4'(k), b[k]);
  endtask

  task automatic pulse_start();
    frame_start = 1'b1;
    step();
    frame_start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic capture(input logic [23:0] p, output logic [23:0] r0, output logic [23:0] r1);
    send_pix(p);
    do @(negedge clk); while (!o_v0);
    r0 = o_p0;
    r1 = o_p1;
    step();
  endtask

  initial begin
    logic [23:0] a0, a1, b0, b1;
    bank_leg = '{32'd1192, 32'd0, 32'd1634, 32'(-228000),
                 32'd1192, 32'(-401), 32'(-833), 32'd139000,
                 32'd1192, 32'd2066, 32'd0, 32'(-283000)};
    bank_ext = '{32'd152568, 32'd0, 32'd209190, 32'hFFF0_0000,
                 32'd152568, 32'(-51380), 32'(-106560), 32'hFF80_0003,
                 32'd152568, 32'd264500, 32'd0, 32'hFF80_0000};
    for (int i = 0; i < 3; i++) begin
      bank_swp[4*i]   = bank_ext[4*i];
      bank_swp[4*i+1] = bank_ext[4*i+2];
      bank_swp[4*i+2] = bank_ext[4*i+1];
      bank_swp[4*i+3] = bank_ext[4*i+3];
    end

    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: state right after reset
    chk(i_rdy0 == 1'b1, "R1", "in_ready after reset", 32'(i_rdy0), 32'd1);
    chk(o_v0 == 1'b0 && o_v1 == 1'b0, "R1", "out_valid after reset", 32'(o_v0 | o_v1), 32'd0);
    chk(o_p0 == 24'd0 && o_p1 == 24'd0, "R1", "out_pix after reset", 32'(o_p0 | o_p1), 32'd0);
    step();

    tag = "R2";
    send_pix(24'h102030); send_pix(24'hFF00A5); send_pix(24'h000000); send_pix(24'h7F8081);
    idle(6);

    tag = "R3";
    load_bank(bank_leg);
    cfg_write(4'd12, 32'h1);
    pulse_start();
    send_pix(24'h808080); send_pix(24'h40C010); send_pix(24'hEB8080); send_pix(24'h10F0A0);
    idle(6);

    tag = "R5";
    send_pix(24'hFFFFFF); send_pix(24'h000000); send_pix(24'hFF00FF); send_pix(24'h00FF00);
    idle(6);

    tag = "R7";
    fork
      for (int k = 0; k < 8; k++) send_pix(24'(k * 24'h111317));
      begin
        idle(3); out_ready = 1'b0; idle(4); out_ready = 1'b1;
        idle(1); out_ready = 1'b0; idle(2); out_ready = 1'b1;
      end
    join
    idle(6);

    tag = "R9";
    cfg_write(4'd0, 32'd2400);
    cfg_write(4'd12, 32'h0);
    send_pix(24'h405060); send_pix(24'hA0B0C0);
    idle(6);

    tag = "R10";
    fork
      for (int k = 0; k < 6; k++) send_pix(24'h203040 + 24'(k * 24'h050403));
      begin idle(2); out_ready = 1'b0; pulse_start(); idle(1); out_ready = 1'b1; end
    join
    idle(6);

    tag = "R11";
    cfg_write(4'd12, 32'h1);
    pulse_start();
    cfg_we = 1'b1; cfg_addr = 4'd12; cfg_wdata = 32'h0; frame_start = 1'b1;
    step();
    cfg_we = 1'b0; frame_start = 1'b0;
    send_pix(24'h8090A0); send_pix(24'h304050);
    idle(6);
    pulse_start();
    send_pix(24'h8090A0);
    idle(6);

    tag = "R8";
    cfg_write(4'd12, 32'h1);
    cfg_write(4'd13, 32'h0);
    cfg_write(4'd14, 32'hFFFF_FFFF);
    cfg_write(4'd15, 32'h1234_5678);
    pulse_start();
    send_pix(24'h556677); send_pix(24'h102030);
    idle(6);

    tag = "R4";
    load_bank(bank_ext);
    pulse_start();
    send_pix(24'h808080); send_pix(24'h10F0A0); send_pix(24'hEB1080); send_pix(24'h5A3CC8);
    idle(6);

    tag = "R12";
    capture(24'h50A060, a0, a1);
    load_bank(bank_swp);
    pulse_start();
    capture(24'hA05060, b0, b1);
    chk(b0 == a0, "R12", "legacy swapped columns", 32'(b0), 32'(a0));
    chk(b1 == a1, "R12", "extended swapped columns", 32'(b1), 32'(a1));
    idle(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog actual=%0d expected=below 20000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule